// File: doc/BRIEF.md
# Deterministic Hardware Thread Issue Scheduler

This block decides, on every clock, which of eight hardware threads may issue one instruction into a shared pipeline. Since every thread keeps its own architectural state, the choice can change from one clock to the next at no cost. Real-time threads are given fixed positions in a sixteen-entry slot table. A slot pointer steps through that table once per clock, so each real-time thread issues at a repeating position in the cycle. Its share of issue bandwidth is the number of entries it holds divided by sixteen. For example, four entries give it a quarter of the pipeline.

Some slots cannot be used by the table. This happens when the entry is empty, or when it names a thread that is disabled or suspended. Such a slot is passed to a round-robin arbiter that serves only the runnable threads not flagged real-time. A thread leaves the eligible set when its suspend request is taken, and a wake line returns it. A control write loads the per-thread enable and real-time flags, and a table write port programs the slot entries. The outputs depend only on the registered state. Inputs seen at a clock edge therefore affect the issue decision from the following cycle onward.

Both the thread count and the slot count must be powers of two.

Top module: `thr_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released: issue_valid is 0, issue_tid is 0, issue_from_table is 0 and issue_slot is 0. Reset also leaves all threads disabled, not suspended and not real-time, makes every table entry invalid, and points the round-robin search at thread 0.
- R2: issue_slot advances by exactly one on every clock and wraps from 15 to 0. It does this whatever the issue decision is.
- R3: Suppose the table entry at issue_slot is valid and the thread it names is enabled and not suspended. Then that thread issues in that cycle with issue_from_table = 1, whatever its real-time flag is.
- R4: Take a thread that is runnable, is flagged real-time, and holds k table entries. Over any 16 consecutive cycles it issues exactly k times.
- R5: If the current slot is not used by the table, it goes to an enabled, non-suspended thread whose real-time flag is 0, with issue_from_table = 0. A thread flagged real-time never receives such a slot.
- R6: The round-robin search starts at the thread after the last thread that won a fallback slot, and goes upward with wrap-around. The start position changes only in a cycle where a fallback slot is actually granted.
- R7: If susp_req[i] = 1 and wake[i] = 0 at a clock edge, thread i does not issue from the next cycle until it is woken.
- R8: If wake[i] = 1 at a clock edge, thread i is not suspended from the next cycle on. This holds even when susp_req[i] = 1 at the same edge.
- R9: A clock edge with ctl_wr = 1 loads ctl_enable and ctl_rt into the thread flags, with bit i belonging to thread i. The new flags take effect from the next cycle, and suspension state is left unchanged.
- R10: In a cycle with no eligible thread, issue_valid = 0, issue_tid = 0 and issue_from_table = 0.
- R11: A clock edge with tbl_wr = 1 stores {tbl_valid, tbl_tid} in entry tbl_addr. The slot read in that same cycle still uses the old contents, and the new entry is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Load the thread flag masks |
| ctl_enable | input | 8 | Per-thread enable mask loaded on ctl_wr |
| ctl_rt | input | 8 | Per-thread real-time flag mask loaded on ctl_wr |
| susp_req | input | 8 | Per-thread suspend request |
| wake | input | 8 | Per-thread wake or interrupt line |
| tbl_wr | input | 1 | Write one slot table entry |
| tbl_addr | input | 4 | Slot table entry to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_tid | input | 3 | Thread ID for the written entry |
| issue_valid | output | 1 | A thread issues in this cycle |
| issue_tid | output | 3 | Thread chosen to issue |
| issue_from_table | output | 1 | The choice came from the slot table |
| issue_slot | output | 4 | Current slot pointer |

## Verification
Every piece of state here shows at the ports within at most one pass through the table. A wrong slot pointer shows at once on issue_slot, and it also moves every real-time issue to the wrong cycle. A corrupted table entry or a wrong flag bit appears the next time that slot comes round, so within 16 cycles, as a wrong thread, a wrong source, or a missing or extra issue. A round-robin pointer that drifts is exposed on the next fallback grant. The bench therefore compares every output against a behavioural model on every cycle, under ordered configuration phases and then under long pseudo-random control traffic.

// File: rtl/thr_sched_pkg.sv
`timescale 1ns/1ps
package thr_sched_pkg;

    localparam int DEF_THREADS = 8;
    localparam int DEF_SLOTS   = 16;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_RR    = 2'd2
    } issue_src_e;

endpackage

// File: rtl/thr_slot_table.sv
`timescale 1ns/1ps
module thr_slot_table #(
    parameter int NUM_SLOTS = 16,
    parameter int TID_W     = 3,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic [TID_W-1:0]  wr_tid,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              cur_valid,
    output logic [TID_W-1:0]  cur_tid
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] tid;
    } ent_t;

    typedef struct packed {
        logic [SLOT_W-1:0]     slot;
        ent_t [NUM_SLOTS-1:0]  tbl;
    } tab_st_t;

    tab_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST_SLOT) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
        if (wr_en) begin
            st_d.tbl[wr_addr].vld = wr_valid;
            st_d.tbl[wr_addr].tid = wr_tid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_slot  = st_q.slot;
    assign cur_valid = st_q.tbl[st_q.slot].vld;
    assign cur_tid   = st_q.tbl[st_q.slot].tid;

    // R2: pointer steps by one and wraps at the last entry
    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != LAST_SLOT) |=> (st_q.slot == $past(st_q.slot) + 1'b1));

    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == LAST_SLOT) |=> (st_q.slot == '0));

    // R11: a written entry holds the written value on the next cycle
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.tbl[$past(wr_addr)].vld == $past(wr_valid)));

endmodule

// File: rtl/thr_state.sv
`timescale 1ns/1ps
module thr_state #(
    parameter int NUM_THREADS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [NUM_THREADS-1:0] ctl_enable,
    input  logic [NUM_THREADS-1:0] ctl_rt,
    input  logic [NUM_THREADS-1:0] susp_req,
    input  logic [NUM_THREADS-1:0] wake,
    output logic [NUM_THREADS-1:0] runnable,
    output logic [NUM_THREADS-1:0] rt_flag
);

    typedef struct packed {
        logic [NUM_THREADS-1:0] en;
        logic [NUM_THREADS-1:0] rt;
        logic [NUM_THREADS-1:0] susp;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.en = ctl_enable;
            st_d.rt = ctl_rt;
        end
        // wake has priority over a suspend taken in the same cycle
        st_d.susp = (st_q.susp | susp_req) & ~wake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign runnable = st_q.en & ~st_q.susp;
    assign rt_flag  = st_q.rt;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_chk
        // R7: suspend without wake leaves the thread suspended
        a_r7_suspend_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (susp_req[i] && !wake[i]) |=> st_q.susp[i]);
        // R8: wake always clears suspension
        a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
            wake[i] |=> !st_q.susp[i]);
        // R9: suspension is untouched by control writes alone
        a_r9_susp_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!susp_req[i] && !wake[i]) |=> $stable(st_q.susp[i]));
    end

endmodule

// File: rtl/thr_rr_arbiter.sv
`timescale 1ns/1ps
module thr_rr_arbiter #(
    parameter int NUM_THREADS = 8,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] req,
    input  logic                   take,
    output logic                   gnt_valid,
    output logic [TID_W-1:0]       gnt_tid
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    typedef struct packed {
        logic [TID_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_tid   = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            int idx;
            idx = (int'(st_q.ptr) + k) % NUM_THREADS;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_tid   = TID_W'(idx);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (take && gnt_valid) begin
            if (gnt_tid == LAST_TID) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = gnt_tid + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the search start holds unless a fallback grant is taken
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && gnt_valid) |=> $stable(st_q.ptr));

    // R6: after a grant the search resumes just past the winner
    a_r6_ptr_next: assert property (@(posedge clk) disable iff (!rst_n)
        (take && gnt_valid && gnt_tid != LAST_TID) |=>
            (st_q.ptr == $past(gnt_tid) + 1'b1));

    // R6: the winner is always a requester
    a_r6_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_tid]);

endmodule

// File: rtl/thr_sched.sv
`timescale 1ns/1ps
module thr_sched
    import thr_sched_pkg::*;
#(
    parameter int NUM_THREADS = DEF_THREADS,
    parameter int NUM_SLOTS   = DEF_SLOTS,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [NUM_THREADS-1:0] ctl_enable,
    input  logic [NUM_THREADS-1:0] ctl_rt,
    input  logic [NUM_THREADS-1:0] susp_req,
    input  logic [NUM_THREADS-1:0] wake,
    input  logic                   tbl_wr,
    input  logic [SLOT_W-1:0]      tbl_addr,
    input  logic                   tbl_valid,
    input  logic [TID_W-1:0]       tbl_tid,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    output logic                   issue_from_table,
    output logic [SLOT_W-1:0]      issue_slot
);

    logic [NUM_THREADS-1:0] runnable;
    logic [NUM_THREADS-1:0] rt_flag;
    logic                   cur_valid;
    logic [TID_W-1:0]       cur_tid;
    logic                   table_hit;
    logic                   gnt_valid;
    logic [TID_W-1:0]       gnt_tid;
    issue_src_e             src;

    thr_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .TID_W     (TID_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr),
        .wr_addr   (tbl_addr),
        .wr_valid  (tbl_valid),
        .wr_tid    (tbl_tid),
        .cur_slot  (issue_slot),
        .cur_valid (cur_valid),
        .cur_tid   (cur_tid)
    );

    thr_state #(
        .NUM_THREADS (NUM_THREADS)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_enable (ctl_enable),
        .ctl_rt     (ctl_rt),
        .susp_req   (susp_req),
        .wake       (wake),
        .runnable   (runnable),
        .rt_flag    (rt_flag)
    );

    assign table_hit = cur_valid && runnable[cur_tid];

    thr_rr_arbiter #(
        .NUM_THREADS (NUM_THREADS)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (runnable & ~rt_flag),
        .take      (!table_hit),
        .gnt_valid (gnt_valid),
        .gnt_tid   (gnt_tid)
    );

    always_comb begin
        if (table_hit) begin
            src = SRC_TABLE;
        end else if (gnt_valid) begin
            src = SRC_RR;
        end else begin
            src = SRC_NONE;
        end
        unique case (src)
            SRC_TABLE: issue_tid = cur_tid;
            SRC_RR:    issue_tid = gnt_tid;
            default:   issue_tid = '0;
        endcase
        issue_valid      = (src != SRC_NONE);
        issue_from_table = (src == SRC_TABLE);
    end

    // R3: only a runnable thread is ever issued
    a_r3_issue_runnable: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> runnable[issue_tid]);

    // R5: fallback slots never go to a real-time thread
    a_r5_fallback_nrt: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_from_table) |-> !rt_flag[issue_tid]);

    // R10: idle cycles drive zero ID and no table source
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_tid == '0 && !issue_from_table));

endmodule

// File: tb/thr_sched_bench.sv
`timescale 1ns/1ps
module thr_sched_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_enable = '0;
    logic [7:0] ctl_rt = '0;
    logic [7:0] susp_req = '0;
    logic [7:0] wake = '0;
    logic       tbl_wr = 1'b0;
    logic [3:0] tbl_addr = '0;
    logic       tbl_valid = 1'b0;
    logic [2:0] tbl_tid = '0;
    logic       issue_valid;
    logic [2:0] issue_tid;
    logic       issue_from_table;
    logic [3:0] issue_slot;

    thr_sched u_thr_sched (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
        .ctl_rt(ctl_rt), .susp_req(susp_req), .wake(wake), .tbl_wr(tbl_wr),
        .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_tid(tbl_tid),
        .issue_valid(issue_valid), .issue_tid(issue_tid),
        .issue_from_table(issue_from_table), .issue_slot(issue_slot)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural model state
    int       m_slot = 0;
    int       m_rr = 0;
    bit [7:0] m_en = '0;
    bit [7:0] m_rt = '0;
    bit [7:0] m_susp = '0;
    bit       m_tv[16];
    int       m_tt[16];
    int       cnt[8];
    int       idle_cnt;

    task automatic model_expect(output bit ev, output int et, output bit etb);
        ev = 0; et = 0; etb = 0;
        if (m_tv[m_slot] && m_en[m_tt[m_slot]] && !m_susp[m_tt[m_slot]]) begin
            ev = 1; et = m_tt[m_slot]; etb = 1;
        end else begin
            for (int k = 0; k < 8; k++) begin
                int c;
                c = (m_rr + k) % 8;
                if (!ev && m_en[c] && !m_susp[c] && !m_rt[c]) begin
                    ev = 1; et = c;
                end
            end
        end
    endtask

    task automatic model_step();
        bit ev; int et; bit etb;
        model_expect(ev, et, etb);
        if (ev && !etb) m_rr = (et + 1) % 8;
        m_slot = (m_slot + 1) % 16;
        if (tbl_wr) begin
            m_tv[tbl_addr] = tbl_valid;
            m_tt[tbl_addr] = int'(tbl_tid);
        end
        if (ctl_wr) begin
            m_en = ctl_enable;
            m_rt = ctl_rt;
        end
        for (int i = 0; i < 8; i++) begin
            if (wake[i]) m_susp[i] = 0;
            else if (susp_req[i]) m_susp[i] = 1;
        end
    endtask

    task automatic compare();
        bit ev; int et; bit etb;
        model_expect(ev, et, etb);
        checks++;
        if (issue_valid !== ev || issue_tid !== 3'(et) || issue_from_table !== etb) begin
            errors++;
            $display("FAIL %s valid/tid/table got %0b/%0d/%0b exp %0b/%0d/%0b",
                     cur_req, issue_valid, issue_tid, issue_from_table, ev, et, etb);
        end
        checks++;
        if (issue_slot !== 4'(m_slot)) begin
            errors++;
            $display("FAIL R2 slot got %0d exp %0d", issue_slot, m_slot);
        end
    endtask

    task automatic check_val(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic clear_cnt();
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        idle_cnt = 0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        if (issue_valid) cnt[issue_tid]++;
        else idle_cnt++;
        ctl_wr = 0; susp_req = '0; wake = '0; tbl_wr = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put_entry(int a, bit v, int t);
        tbl_wr = 1; tbl_addr = 4'(a); tbl_valid = v; tbl_tid = 3'(t);
        tick();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_tv[i] = 0; m_tt[i] = 0; end
        clear_cnt();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        tick();                       // first cycle after release: R1

        // R9: enable all threads as non-real-time
        cur_req = "R9";
        ctl_wr = 1; ctl_enable = 8'hFF; ctl_rt = 8'h00;
        tick();
        cur_req = "R6";
        run(3);
        clear_cnt();
        run(16);
        for (int i = 0; i < 8; i++) check_val("R6 equal share", cnt[i], 2);

        // R11: program the table (thread 0 x4, thread 1 x2, thread 3 x1)
        cur_req = "R11";
        ctl_wr = 1; ctl_enable = 8'hFF; ctl_rt = 8'h03;
        put_entry(0, 1, 0);
        put_entry(4, 1, 0);
        put_entry(8, 1, 0);
        put_entry(12, 1, 0);
        put_entry(2, 1, 1);
        put_entry(10, 1, 1);
        put_entry(6, 1, 3);
        put_entry(7, 0, 5);
        cur_req = "R3";
        run(20);
        clear_cnt();
        run(16);
        check_val("R4 thread0 share", cnt[0], 4);
        check_val("R4 thread1 share", cnt[1], 2);

        // R7: suspend real-time thread 0
        cur_req = "R7";
        susp_req = 8'h01;
        tick();
        cur_req = "R5";
        clear_cnt();
        run(16);
        check_val("R7 suspended thread0 issues", cnt[0], 0);
        check_val("R5 no idle with nrt threads", idle_cnt, 0);

        // R8: wake thread 0; suspend and wake thread 1 together
        cur_req = "R8";
        wake = 8'h01;
        tick();
        susp_req = 8'h02; wake = 8'h02;
        tick();
        clear_cnt();
        run(16);
        check_val("R8 thread1 still runs", cnt[1], 2);
        check_val("R8 thread0 back", cnt[0], 4);

        // R10: only threads 0 and 1 enabled; remaining slots idle
        cur_req = "R10";
        ctl_wr = 1; ctl_enable = 8'h03; ctl_rt = 8'h03;
        tick();
        clear_cnt();
        run(16);
        check_val("R10 idle cycles", idle_cnt, 10);
        ctl_wr = 1; ctl_enable = 8'h00; ctl_rt = 8'h00;
        tick();
        clear_cnt();
        run(16);
        check_val("R10 all disabled idle", idle_cnt, 16);

        // R6: pseudo-random traffic
        cur_req = "R6";
        begin
            logic [31:0] lf;
            lf = 32'h1ACE_B00C;
            for (int n = 0; n < 1500; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                if (lf[3:0] == 4'd0) begin
                    ctl_wr = 1; ctl_enable = lf[15:8]; ctl_rt = lf[23:16] & lf[31:24];
                end
                susp_req = lf[11:4] & lf[19:12] & lf[27:20];
                wake     = lf[14:7] & lf[24:17];
                if (lf[5:4] == 2'd1) begin
                    tbl_wr = 1; tbl_addr = lf[29:26]; tbl_valid = lf[30]; tbl_tid = lf[18:16];
                end
                tick();
            end
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule